// File: doc/BRIEF.md
# Peripheral Request Router

This block steers hardware peripheral request lines onto DMA channels. Every hardware request identifier, numbered from one, owns a small mapping register in a global register window. Software writes the target channel number plus one into that register to connect the request, or zero to disconnect it. Identifier zero stands for transfers started by software and has no mapping register.

The block turns each rising edge of a request input into a one-cycle request pulse on the channel it is mapped to. When several identifiers point at one channel, their pulses are merged onto it. The block also gathers per-channel interrupt and activity levels into global status words that software can read, and it raises one summary interrupt when any enabled channel interrupt is pending. The register port is a plain control port with no back-pressure. A write completes in the cycle it is presented. Read data comes back one cycle after the read strobe, flagged by a valid pin. The request lines and channel pulses are plain level and pulse wires.

Top module: `req_chan_router`

## Requirements
- R1: After reset every mapping register reads zero, no channel request pulse is driven, the summary interrupt is low, and the read data bus is zero.
- R2: Writing a value v with 1 <= v <= NUM_CH to byte offset 0x2000 + 4*(u-1), for identifier u in 1..NUM_REQ, stores v. A read of that offset returns v in the low bits, with upper bits zero. `reg_rd_valid` is high exactly one cycle after `reg_rd_en`, and `reg_rdata` holds zero whenever `reg_rd_valid` is low.
- R3: Identifier u is carried on `periph_req_i[u-1]`. When identifier u is mapped to value v and its line rises, `ch_req_o[v-1]` is high for exactly one cycle, starting on the clock edge that first samples the line high. A line that stays high produces no further pulse.
- R4: Writing zero to a mapping register disconnects that identifier, so later edges on its line drive no channel.
- R5: When two or more identifiers are mapped to the same channel, their pulses are ORed onto that channel's output.
- R6: A write whose full data value exceeds NUM_CH is discarded, and the mapping register keeps its previous value.
- R7: Offset 0x10 reads the raw channel interrupt levels, with bit i for channel i. Offset 0x1C reads the channel active levels. Offset 0x14 reads the masked status, which is raw AND enable as registered on the previous clock edge.
- R8: `irq_o` is high in a cycle exactly when, at the previous clock edge, some channel had both its raw interrupt and its enable high.
- R9: Reads of any other offset return zero. This covers offset 0x0, the slot just below 0x2000 where identifier zero would sit, the offset just past the last identifier, and unaligned offsets. Writes to such offsets change no mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset in the global window |
| reg_wdata | input | DATA_W | Write data |
| reg_rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| reg_rdata | output | DATA_W | Read data, zero when not valid |
| periph_req_i | input | NUM_REQ | Peripheral request lines, bit k is identifier k+1 |
| ch_req_o | output | NUM_CH | Per-channel request pulses |
| ch_irq_raw | input | NUM_CH | Per-channel raw interrupt levels |
| ch_irq_en | input | NUM_CH | Per-channel interrupt enables |
| ch_active | input | NUM_CH | Per-channel active levels |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bench builds the block with eight identifiers, four channels and the default 14-bit offset and 32-bit data widths. Eight identifiers on four channels force channel sharing, so merged pulses come up often. The 3-bit mapping field can hold the values 5 to 7, which lie above the channel count, so discarded writes can be told apart from a truncated store. The window reaches 0x201C, which puts both edge slots (0x1FFC and 0x2020) inside the decoded address range.

// File: rtl/router_pkg.sv
package router_pkg;

  // Byte offsets inside the global register window
  localparam int unsigned OFS_IRQ_RAW  = 32'h0000_0010;
  localparam int unsigned OFS_IRQ_MSK  = 32'h0000_0014;
  localparam int unsigned OFS_CH_ACT   = 32'h0000_001C;
  localparam int unsigned OFS_MAP_BASE = 32'h0000_2000;

  // Read source selected by the address decoder
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_MSK,
    SEL_ACT,
    SEL_MAP
  } rd_sel_e;

endpackage

// File: rtl/router_map_regs.sv
module router_map_regs
  import router_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32,
  parameter int MAP_W   = $clog2(NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_CH-1:0]        irq_raw,
  input  logic [NUM_CH-1:0]        irq_msk,
  input  logic [NUM_CH-1:0]        ch_act,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rdata,
  output logic [NUM_REQ*MAP_W-1:0] map_flat
);

  logic [31:0]        addr_ext;
  logic [NUM_REQ-1:0] map_hit;
  logic [MAP_W-1:0]   map_q [NUM_REQ];
  logic               wr_legal;
  rd_sel_e            sel;
  logic [MAP_W-1:0]   map_rd;
  logic [DATA_W-1:0]  rd_next;

  assign addr_ext = 32'(addr);
  // Values above the channel count are discarded whole
  assign wr_legal = (wdata <= DATA_W'(NUM_CH));

  // One mapping register per hardware identifier (identifier r+1)
  for (genvar r = 0; r < NUM_REQ; r++) begin : g_map
    assign map_hit[r] = (addr_ext == 32'(OFS_MAP_BASE + 4 * r));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        map_q[r] <= '0;
      end else if (wr_en && map_hit[r] && wr_legal) begin
        map_q[r] <= wdata[MAP_W-1:0];
      end
    end

    assign map_flat[r*MAP_W +: MAP_W] = map_q[r];
  end

  always_comb begin
    if (|map_hit) begin
      sel = SEL_MAP;
    end else begin
      unique case (addr_ext)
        OFS_IRQ_RAW: sel = SEL_RAW;
        OFS_IRQ_MSK: sel = SEL_MSK;
        OFS_CH_ACT:  sel = SEL_ACT;
        default:     sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    map_rd = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (map_hit[r]) map_rd = map_rd | map_q[r];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_RAW: rd_next = DATA_W'(irq_raw);
      SEL_MSK: rd_next = DATA_W'(irq_msk);
      SEL_ACT: rd_next = DATA_W'(ch_act);
      SEL_MAP: rd_next = DATA_W'(map_rd);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_en;
      rdata    <= rd_en ? rd_next : '0;
    end
  end

endmodule

// File: rtl/router_xbar.sv
module router_xbar #(
  parameter int NUM_REQ = 8,
  parameter int NUM_CH  = 4,
  parameter int MAP_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REQ-1:0]       req_i,
  input  logic [NUM_REQ*MAP_W-1:0] map_flat,
  output logic [NUM_CH-1:0]        ch_req_o
);

  logic [NUM_REQ-1:0] req_q;
  logic [NUM_REQ-1:0] rise;
  logic [NUM_CH-1:0]  route;

  assign rise = req_i & ~req_q;

  // Each channel collects the edges of every identifier pointing at it
  always_comb begin
    route = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (map_flat[r*MAP_W +: MAP_W] == MAP_W'(c + 1)) begin
          route[c] = route[c] | rise[r];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= '0;
      ch_req_o <= '0;
    end else begin
      req_q    <= req_i;
      ch_req_o <= route;
    end
  end

endmodule

// File: rtl/router_irq_sum.sv
module router_irq_sum #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_raw,
  input  logic [NUM_CH-1:0] irq_en,
  output logic [NUM_CH-1:0] irq_msk,
  output logic              irq_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_msk <= '0;
    else        irq_msk <= irq_raw & irq_en;
  end

  assign irq_o = |irq_msk;

endmodule

// File: rtl/req_chan_router.sv
module req_chan_router #(
  parameter int NUM_REQ = 8,
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic               reg_rd_valid,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_REQ-1:0] periph_req_i,
  output logic [NUM_CH-1:0]  ch_req_o,
  input  logic [NUM_CH-1:0]  ch_irq_raw,
  input  logic [NUM_CH-1:0]  ch_irq_en,
  input  logic [NUM_CH-1:0]  ch_active,
  output logic               irq_o
);

  localparam int MAP_W = $clog2(NUM_CH + 1);

  logic [NUM_REQ*MAP_W-1:0] map_flat;
  logic [NUM_CH-1:0]        irq_msk;

  router_map_regs #(
    .NUM_REQ (NUM_REQ),
    .NUM_CH  (NUM_CH),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MAP_W   (MAP_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .rd_en    (reg_rd_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .irq_raw  (ch_irq_raw),
    .irq_msk  (irq_msk),
    .ch_act   (ch_active),
    .rd_valid (reg_rd_valid),
    .rdata    (reg_rdata),
    .map_flat (map_flat)
  );

  router_xbar #(
    .NUM_REQ (NUM_REQ),
    .NUM_CH  (NUM_CH),
    .MAP_W   (MAP_W)
  ) u_xbar (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (periph_req_i),
    .map_flat (map_flat),
    .ch_req_o (ch_req_o)
  );

  router_irq_sum #(
    .NUM_CH (NUM_CH)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_raw (ch_irq_raw),
    .irq_en  (ch_irq_en),
    .irq_msk (irq_msk),
    .irq_o   (irq_o)
  );

endmodule

// File: rtl/router_chk.sv
module router_chk #(
  parameter int NUM_REQ = 8,
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_rd_en,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_rd_valid,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [NUM_REQ-1:0] periph_req_i,
  input logic [NUM_CH-1:0]  ch_req_o,
  input logic [NUM_CH-1:0]  ch_irq_raw,
  input logic [NUM_CH-1:0]  ch_irq_en,
  input logic               irq_o
);

  // R2: read data is flagged exactly one cycle after the strobe
  a_r2_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_valid == $past(reg_rd_en));

  // R2: idle read bus carries zero
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_valid |-> reg_rdata == '0);

  // R3: a channel pulse needs a request line high one edge earlier
  a_r3_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_req_o) |-> $past(|periph_req_i));

  // R7: raw status read returns the levels present at the strobe
  a_r7_raw_read: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd_en && reg_addr == ADDR_W'(16'h0010))
      |-> reg_rdata == DATA_W'($past(ch_irq_raw)));

  // R8: summary interrupt follows enabled pending levels by one edge
  a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|(ch_irq_raw & ch_irq_en)) |-> irq_o);

  a_r8_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|(ch_irq_raw & ch_irq_en)) |-> !irq_o);

  // R9: offsets below the first status word read zero
  a_r9_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd_en && reg_addr < ADDR_W'(16'h0010)) |-> reg_rdata == '0);

endmodule

bind req_chan_router router_chk #(
  .NUM_REQ (NUM_REQ),
  .NUM_CH  (NUM_CH),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_rd_en    (reg_rd_en),
  .reg_addr     (reg_addr),
  .reg_rd_valid (reg_rd_valid),
  .reg_rdata    (reg_rdata),
  .periph_req_i (periph_req_i),
  .ch_req_o     (ch_req_o),
  .ch_irq_raw   (ch_irq_raw),
  .ch_irq_en    (ch_irq_en),
  .irq_o        (irq_o)
);

// File: tb/sim_req_chan_router.sv
module sim_req_chan_router;

  localparam int NUM_REQ = 8;
  localparam int NUM_CH  = 4;
  localparam int ADDR_W  = 14;
  localparam int DATA_W  = 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               reg_wr_en = 1'b0;
  logic               reg_rd_en = 1'b0;
  logic [ADDR_W-1:0]  reg_addr = '0;
  logic [DATA_W-1:0]  reg_wdata = '0;
  logic               reg_rd_valid;
  logic [DATA_W-1:0]  reg_rdata;
  logic [NUM_REQ-1:0] periph_req_i = '0;
  logic [NUM_CH-1:0]  ch_req_o;
  logic [NUM_CH-1:0]  ch_irq_raw = '0;
  logic [NUM_CH-1:0]  ch_irq_en = '0;
  logic [NUM_CH-1:0]  ch_active = '0;
  logic               irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  int model_map [NUM_REQ];

  always #4 clk = ~clk;

  req_chan_router #(
    .NUM_REQ (NUM_REQ), .NUM_CH (NUM_CH), .ADDR_W (ADDR_W), .DATA_W (DATA_W)
  ) u0 (
    .clk (clk), .rst_n (rst_n),
    .reg_wr_en (reg_wr_en), .reg_rd_en (reg_rd_en), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rd_valid (reg_rd_valid), .reg_rdata (reg_rdata),
    .periph_req_i (periph_req_i), .ch_req_o (ch_req_o),
    .ch_irq_raw (ch_irq_raw), .ch_irq_en (ch_irq_en), .ch_active (ch_active),
    .irq_o (irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] map_addr(input int uid);
    return ADDR_W'(32'h2000 + 4 * (uid - 1));
  endfunction

  function automatic logic [NUM_CH-1:0] exp_route(input logic [NUM_REQ-1:0] m);
    logic [NUM_CH-1:0] e = '0;
    for (int r = 0; r < NUM_REQ; r++)
      if (m[r] && model_map[r] >= 1 && model_map[r] <= NUM_CH)
        e[model_map[r] - 1] = 1'b1;
    return e;
  endfunction

  task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    check(reg_rd_valid == 1'b1, "R2 rd_valid", 32'(reg_rd_valid), 32'd1);
    d = reg_rdata;
  endtask

  // Write through the model: only legal values land
  task automatic map_write(input int uid, input logic [DATA_W-1:0] v);
    reg_write(map_addr(uid), v);
    if (v <= DATA_W'(NUM_CH)) model_map[uid - 1] = int'(v);
  endtask

  task automatic map_check(input int uid, input string req);
    logic [DATA_W-1:0] d;
    reg_read(map_addr(uid), d);
    check(d == DATA_W'(model_map[uid - 1]), req, d, 32'(model_map[uid - 1]));
  endtask

  task automatic fire(input logic [NUM_REQ-1:0] m, input string req);
    logic [NUM_CH-1:0] e;
    e = exp_route(m);
    periph_req_i = m;
    @(negedge clk);
    check(ch_req_o == e, req, 32'(ch_req_o), 32'(e));
    @(negedge clk);
    check(ch_req_o == '0, "R3 held line no repeat", 32'(ch_req_o), 32'd0);
    periph_req_i = '0;
    @(negedge clk);
  endtask

  initial begin
    logic [DATA_W-1:0] d;
    int seed_init;
    seed_init = $urandom(32'd7781);
    for (int r = 0; r < NUM_REQ; r++) model_map[r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(ch_req_o == '0, "R1 ch_req_o", 32'(ch_req_o), 0);
    check(irq_o == 1'b0, "R1 irq_o", 32'(irq_o), 0);
    check(reg_rdata == '0, "R1 rdata", reg_rdata, 0);
    for (int u = 1; u <= NUM_REQ; u++) map_check(u, "R1 map reset");
    fire('1, "R1 nothing routed after reset");

    // R2 / R3 basic routing
    map_write(1, 1);
    map_check(1, "R2 readback");
    fire(8'b0000_0001, "R3 uid1 to ch0");
    map_write(8, 4);
    map_check(8, "R2 readback last uid");
    fire(8'b1000_0000, "R3 uid8 to ch3");

    // R5 shared channel
    map_write(3, 1);
    fire(8'b0000_0100, "R5 uid3 alone");
    fire(8'b0000_0101, "R5 uid1 and uid3 merged");

    // R6 out-of-range values discarded
    map_write(1, NUM_CH + 1);
    map_check(1, "R6 value NUM_CH+1 discarded");
    map_write(1, 32'h8000_0001);
    map_check(1, "R6 wide value discarded");
    fire(8'b0000_0001, "R6 old route kept");

    // R4 unmapping
    map_write(1, 0);
    map_check(1, "R4 unmapped reads zero");
    fire(8'b0000_0001, "R4 unmapped drives nothing");

    // R9 reserved offsets
    reg_write(ADDR_W'(32'h1FFC), 2);
    reg_write(ADDR_W'(32'h2002), 3);
    reg_write(ADDR_W'(32'h2000 + 4 * NUM_REQ), 2);
    foreach (model_map[r]) map_check(r + 1, "R9 map untouched");
    reg_read(ADDR_W'(32'h0000), d);
    check(d == '0, "R9 offset 0", d, 0);
    reg_read(ADDR_W'(32'h1FFC), d);
    check(d == '0, "R9 identifier zero slot", d, 0);
    reg_read(ADDR_W'(32'h2000 + 4 * NUM_REQ), d);
    check(d == '0, "R9 past last identifier", d, 0);
    reg_read(ADDR_W'(32'h2002), d);
    check(d == '0, "R9 unaligned", d, 0);

    // R7 / R8 directed interrupt summary
    ch_irq_raw = 4'b0101; ch_irq_en = 4'b0100; ch_active = 4'b1001;
    @(negedge clk); @(negedge clk);
    check(irq_o == 1'b1, "R8 irq set", 32'(irq_o), 1);
    reg_read(ADDR_W'(32'h10), d);
    check(d == 32'h5, "R7 raw", d, 32'h5);
    reg_read(ADDR_W'(32'h14), d);
    check(d == 32'h4, "R7 masked", d, 32'h4);
    reg_read(ADDR_W'(32'h1C), d);
    check(d == 32'h9, "R7 active", d, 32'h9);
    ch_irq_en = 4'b1010;
    @(negedge clk); @(negedge clk);
    check(irq_o == 1'b0, "R8 irq clear", 32'(irq_o), 0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      int uid;
      op  = int'($urandom_range(0, 3));
      uid = int'($urandom_range(1, NUM_REQ));
      case (op)
        0: begin
          if ($urandom_range(0, 7) == 0) map_write(uid, $urandom());
          else map_write(uid, DATA_W'($urandom_range(0, 7)));
        end
        1: map_check(uid, "R2 random readback");
        2: fire(NUM_REQ'($urandom()), "R3 R5 random route");
        default: begin
          logic [NUM_CH-1:0] rw, en;
          rw = NUM_CH'($urandom()); en = NUM_CH'($urandom());
          ch_irq_raw = rw; ch_irq_en = en; ch_active = NUM_CH'($urandom());
          @(negedge clk); @(negedge clk);
          check(irq_o == |(rw & en), "R8 random irq", 32'(irq_o), 32'(|(rw & en)));
          reg_read(ADDR_W'(32'h14), d);
          check(d == DATA_W'(rw & en), "R7 random masked", d, 32'(rw & en));
          reg_read(ADDR_W'(32'h1C), d);
          check(d == DATA_W'(ch_active), "R7 random active", d, 32'(ch_active));
        end
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule